// File: doc/BRIEF.md
# Parity Serial Character Transmitter

This block turns a parallel word into one asynchronous serial character on a single output line. A one-cycle write strobe captures the word together with a parity-sense select. The line then carries, from first to last: a low start bit, the data bits beginning with the least significant, one parity bit, and enough high stop bits to fill the configured character length. Every bit holds for a fixed number of clock cycles. Between characters the line rests high.

A busy flag covers the whole character. A source that watches it can chain characters with no idle gap. A strobe given in the very last clock cycle of the final stop bit is taken at once, and its start bit follows that stop bit directly. The bit period, the character length and the data width are parameters. The number of stop bits follows from the character length. The parity sense is chosen per character at run time.

Top module: `ser_char_tx`

## Requirements
- R1: Whenever `busy` is low, `txd` is high. This includes the state after reset.
- R2: A strobe on `wr_stb` while `busy` is low is sampled at a rising clock edge. After that same edge `busy` is high and `txd` is low (start bit).
- R3: Every bit of a character holds `txd` steady for exactly `CYC_PER_BIT` clock cycles.
- R4: A character is `CHAR_BITS` bits long, in this position order:
  - position 0 is the start bit (0);
  - positions 1..`WORD_BITS` carry data bits 0..`WORD_BITS`-1, least significant first;
  - position `WORD_BITS`+1 is the parity bit;
  - every later position is a stop bit (1).
- R5: The parity bit equals `odd_sel` XOR the XOR of all data bits. Odd parity is `odd_sel`=1 and even parity is `odd_sel`=0.
- R6: `busy` stays high for exactly `CHAR_BITS`×`CYC_PER_BIT` cycles. It falls at the end of the last stop bit, with `txd` high.
- R7: A strobe while `busy` is high is ignored, except in the final cycle of the final stop bit. An ignored strobe neither restarts nor lengthens the character, and adds no character.
- R8: A strobe in the final cycle of the final stop bit is accepted. `busy` stays high, and the next start bit begins right after that stop bit, so successive starts are `CHAR_BITS`×`CYC_PER_BIT` cycles apart.
- R9: An active-high `rst` acts asynchronously. It forces `txd` high and `busy` low at once, even in the middle of a character.
- R10: Data and parity select are captured with the strobe. Changing `wr_data` or `odd_sel` during a character has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| wr_stb | input | 1 | One-cycle request to send a character |
| wr_data | input | WORD_BITS | Word to send, captured with the strobe |
| odd_sel | input | 1 | Parity sense: 1 odd, 0 even, captured with the strobe |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | High for the duration of a character |

## Verification
Words of all zeros, all ones, alternating bits, a lone top bit and a lone bottom bit are sent under both parity senses. This separates a reversed bit order, a shifted bit position and a wrong parity sense, because each of these faults corrupts some of these words and not others. One character is followed cycle by cycle to pin down where the start bit begins, where the first bit boundary falls and where `busy` ends. A chained pair shows whether a strobe in the final stop cycle is taken without a gap. Strobes given mid-character and one cycle before the final cycle show whether the window for acceptance is too wide. A reset in the middle of a character and a send after it confirm that the line recovers.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

   typedef enum logic {
      TX_IDLE = 1'b0,
      TX_SEND = 1'b1
   } tx_state_e;

   // width of a down-counter that must hold span-1
   function automatic int unsigned ctr_width(input int unsigned span);
      return (span > 1) ? $clog2(span) : 1;
   endfunction

endpackage

// File: rtl/tx_bit_timer.sv
module tx_bit_timer
   import ser_tx_pkg::*;
#(
   parameter int unsigned CYC_PER_BIT = 20
)(
   input  logic clk,
   input  logic rst,
   input  logic load,
   input  logic run,
   output logic tick
);
   localparam int unsigned TW = ctr_width(CYC_PER_BIT);
   localparam logic [TW-1:0] TOP = TW'(CYC_PER_BIT - 1);

   logic [TW-1:0] cnt_q;

   // counts down through one bit period; tick marks its last cycle
   always_ff @(posedge clk or posedge rst) begin
      if (rst)
         cnt_q <= '0;
      else if (load)
         cnt_q <= TOP;
      else if (run)
         cnt_q <= (cnt_q == '0) ? TOP : cnt_q - 1'b1;
   end

   assign tick = (cnt_q == '0);
endmodule

// File: rtl/tx_bit_count.sv
module tx_bit_count
   import ser_tx_pkg::*;
#(
   parameter int unsigned CHAR_BITS = 15
)(
   input  logic clk,
   input  logic rst,
   input  logic load,
   input  logic step,
   output logic last
);
   localparam int unsigned CW = ctr_width(CHAR_BITS);
   localparam logic [CW-1:0] TOP = CW'(CHAR_BITS - 1);

   logic [CW-1:0] cnt_q;

   // bits still to go after the current one
   always_ff @(posedge clk or posedge rst) begin
      if (rst)
         cnt_q <= '0;
      else if (load)
         cnt_q <= TOP;
      else if (step && (cnt_q != '0))
         cnt_q <= cnt_q - 1'b1;
   end

   assign last = (cnt_q == '0);
endmodule

// File: rtl/tx_frame_sr.sv
module tx_frame_sr #(
   parameter int unsigned WORD_BITS = 12,
   parameter int unsigned CHAR_BITS = 15
)(
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 load,
   input  logic                 shift,
   input  logic [WORD_BITS-1:0] data,
   input  logic                 odd_sel,
   output logic                 ser
);
   localparam int unsigned STOPS = CHAR_BITS - WORD_BITS - 2;

   logic                 par;
   logic [CHAR_BITS-1:0] frame_w;
   logic [CHAR_BITS-1:0] sr_q;
   logic [CHAR_BITS-1:0] fill_w;

   assign par     = odd_sel ^ (^data);
   assign frame_w = {{STOPS{1'b1}}, par, data, 1'b0};

   // one flop per character position; ones enter from the top so the
   // register drains to the idle level by the end of a character
   for (genvar g = 0; g < CHAR_BITS; g++) begin : g_pos
      if (g == CHAR_BITS - 1) begin : g_top
         assign fill_w[g] = 1'b1;
      end else begin : g_mid
         assign fill_w[g] = sr_q[g+1];
      end

      always_ff @(posedge clk or posedge rst) begin
         if (rst)
            sr_q[g] <= 1'b1;
         else if (load)
            sr_q[g] <= frame_w[g];
         else if (shift)
            sr_q[g] <= fill_w[g];
      end
   end

   assign ser = sr_q[0];
endmodule

// File: rtl/ser_char_tx.sv
module ser_char_tx
   import ser_tx_pkg::*;
#(
   parameter int unsigned CYC_PER_BIT = 20,
   parameter int unsigned CHAR_BITS   = 15,
   parameter int unsigned WORD_BITS   = 12
)(
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 wr_stb,
   input  logic [WORD_BITS-1:0] wr_data,
   input  logic                 odd_sel,
   output logic                 txd,
   output logic                 busy
);
   // elaboration-time parameter checks
   if (CYC_PER_BIT < 1) begin : g_bad_period
      $error("ser_char_tx: CYC_PER_BIT must be at least 1");
   end
   if (WORD_BITS < 1) begin : g_bad_word
      $error("ser_char_tx: WORD_BITS must be at least 1");
   end
   if (CHAR_BITS < WORD_BITS + 3) begin : g_bad_char
      $error("ser_char_tx: CHAR_BITS must leave room for start, parity and a stop bit");
   end

   tx_state_e state_q;
   logic      tick;
   logic      last;
   logic      sending;
   logic      final_cyc;
   logic      accept;
   logic      advance;

   assign sending   = (state_q == TX_SEND);
   assign final_cyc = sending && tick && last;
   assign accept    = wr_stb && (!sending || final_cyc);
   assign advance   = sending && tick && !last;

   always_ff @(posedge clk or posedge rst) begin
      if (rst)
         state_q <= TX_IDLE;
      else if (accept)
         state_q <= TX_SEND;
      else if (final_cyc)
         state_q <= TX_IDLE;
   end

   tx_bit_timer #(.CYC_PER_BIT(CYC_PER_BIT)) u_timer (
      .clk  (clk),
      .rst  (rst),
      .load (accept),
      .run  (sending),
      .tick (tick)
   );

   tx_bit_count #(.CHAR_BITS(CHAR_BITS)) u_count (
      .clk  (clk),
      .rst  (rst),
      .load (accept),
      .step (advance),
      .last (last)
   );

   tx_frame_sr #(.WORD_BITS(WORD_BITS), .CHAR_BITS(CHAR_BITS)) u_sr (
      .clk     (clk),
      .rst     (rst),
      .load    (accept),
      .shift   (advance),
      .data    (wr_data),
      .odd_sel (odd_sel),
      .ser     (txd)
   );

   assign busy = sending;
endmodule

// File: rtl/ser_char_tx_chk.sv
module ser_char_tx_chk
   import ser_tx_pkg::*;
#(
   parameter int unsigned CYC_PER_BIT = 20,
   parameter int unsigned CHAR_BITS   = 15
)(
   input logic clk,
   input logic rst,
   input logic wr_stb,
   input logic txd,
   input logic busy
);
   localparam int unsigned PW = ctr_width(CYC_PER_BIT);
   localparam int unsigned NW = ctr_width(CHAR_BITS);
   localparam logic [PW-1:0] PH_END = PW'(CYC_PER_BIT - 1);
   localparam logic [NW-1:0] NB_END = NW'(CHAR_BITS - 1);

   logic [PW-1:0] ph_q;
   logic [NW-1:0] nb_q;

   // independent phase and bit tracking, driven only from busy
   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         ph_q <= '0;
         nb_q <= '0;
      end else if (!busy) begin
         ph_q <= '0;
         nb_q <= '0;
      end else if (ph_q == PH_END) begin
         ph_q <= '0;
         nb_q <= (nb_q == NB_END) ? '0 : nb_q + 1'b1;
      end else begin
         ph_q <= ph_q + 1'b1;
      end
   end

   // R1
   idle_high_chk: assert property (@(posedge clk) disable iff (rst)
      !busy |-> txd);

   // R2
   start_on_accept_chk: assert property (@(posedge clk) disable iff (rst)
      (!busy && wr_stb) |=> (busy && !txd));

   // R3
   bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && ph_q != '0) |-> $stable(txd));

   // R6
   char_len_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> ($past(nb_q) == NB_END && $past(ph_q) == PH_END && txd));

   // R7
   no_early_end_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && !(ph_q == PH_END && nb_q == NB_END)) |=> busy);

   // R8
   chain_start_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && ph_q == PH_END && nb_q == NB_END && wr_stb) |=> (busy && !txd));
endmodule

bind ser_char_tx ser_char_tx_chk #(
   .CYC_PER_BIT (CYC_PER_BIT),
   .CHAR_BITS   (CHAR_BITS)
) u_chk (
   .clk    (clk),
   .rst    (rst),
   .wr_stb (wr_stb),
   .txd    (txd),
   .busy   (busy)
);

// File: tb/ser_char_tx_tb.sv
module ser_char_tx_tb;
   localparam int CLK_PERIOD = 10;
   localparam int CPB = 20;
   localparam int NB  = 15;
   localparam int WB  = 12;
   localparam int CHAR_CYC = NB * CPB;

   typedef struct packed {
      logic [WB-1:0] d;
      logic          odd;
   } item_t;

   logic          clk = 1'b0;
   logic          rst;
   logic          wr_stb;
   logic [WB-1:0] wr_data;
   logic          odd_sel;
   logic          txd;
   logic          busy;

   int   n_cmp = 0;
   int   n_bad = 0;
   int   frames_seen = 0;
   int   frames_sent = 0;
   int   cyc = 0;
   logic mon_off = 1'b0;
   item_t expq[$];
   int    starts[$];

   ser_char_tx #(.CYC_PER_BIT(CPB), .CHAR_BITS(NB), .WORD_BITS(WB)) u_dut (
      .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data),
      .odd_sel(odd_sel), .txd(txd), .busy(busy)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   // driver: caller stands at a falling edge; returns one cycle later
   task automatic send(input logic [WB-1:0] d, input logic o, input bit push);
      wr_data = d;
      odd_sel = o;
      wr_stb  = 1'b1;
      if (push) begin
         expq.push_back('{d: d, odd: o});
         frames_sent++;
      end
      @(negedge clk);
      wr_stb = 1'b0;
   endtask

   // monitor: decode each character at mid-bit and score it
   initial begin
      forever begin
         @(negedge clk);
         if (!rst && !mon_off && txd == 1'b0) begin
            logic [NB-1:0] fb;
            logic          bsy_all;
            item_t         e;
            starts.push_back(cyc);
            repeat (CPB/2) @(negedge clk);
            fb[0]   = txd;
            bsy_all = busy;
            for (int i = 1; i < NB; i++) begin
               repeat (CPB) @(negedge clk);
               fb[i]   = txd;
               bsy_all = bsy_all & busy;
            end
            frames_seen++;
            if (expq.size() == 0) begin
               check(1'b0, "R7 unexpected character", 32'(fb), 32'h0);
            end else begin
               e = expq.pop_front();
               check(fb[0] == 1'b0, "R4 start bit", 32'(fb[0]), 32'h0);
               check(fb[WB:1] == e.d, "R4 R10 data bits", 32'(fb[WB:1]), 32'(e.d));
               check(fb[WB+1] == (e.odd ^ (^e.d)), "R5 parity bit",
                     32'(fb[WB+1]), 32'(e.odd ^ (^e.d)));
               check(&fb[NB-1:WB+2], "R4 stop bits", 32'(fb[NB-1:WB+2]),
                     32'((1 << (NB-WB-2)) - 1));
               check(bsy_all, "R6 busy through character", 32'(bsy_all), 32'h1);
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [WB-1:0] pats [6];
      pats[0] = '0;
      pats[1] = '1;
      pats[2] = WB'(12'h555);
      pats[3] = WB'(12'hAAA);
      pats[4] = WB'(12'h800);
      pats[5] = WB'(12'h001);

      rst = 1'b1; wr_stb = 1'b0; wr_data = '0; odd_sel = 1'b0;
      repeat (3) @(negedge clk);
      check(txd == 1'b1 && busy == 1'b0, "R1 R9 reset state", {txd, busy}, 2'b10);
      rst = 1'b0;
      repeat (5) @(negedge clk);
      check(txd == 1'b1 && busy == 1'b0, "R1 idle after reset", {txd, busy}, 2'b10);

      // one character followed cycle by cycle
      send(WB'(12'h5A3), 1'b0, 1'b1);
      check(busy == 1'b1 && txd == 1'b0, "R2 start after strobe", {busy, txd}, 2'b10);
      wr_data = ~wr_data;               // R10: changes must not reach the line
      odd_sel = 1'b1;
      repeat (CPB-1) @(negedge clk);
      check(txd == 1'b0, "R3 start bit held full period", txd, 1'b0);
      @(negedge clk);
      check(txd == 1'b1, "R3 first data bit at boundary", txd, 1'b1);
      repeat (CHAR_CYC - CPB - 1) @(negedge clk);
      check(busy == 1'b1 && txd == 1'b1, "R6 last stop cycle", {busy, txd}, 2'b11);
      @(negedge clk);
      check(busy == 1'b0 && txd == 1'b1, "R6 busy ends", {busy, txd}, 2'b01);
      repeat (20) @(negedge clk);

      // pattern sweep under both parity senses
      for (int p = 0; p < 6; p++) begin
         for (int o = 0; o < 2; o++) begin
            send(pats[p], o[0], 1'b1);
            repeat (CHAR_CYC + 3 + p) @(negedge clk);
         end
      end

      // chained pair
      send(WB'(12'h3C5), 1'b1, 1'b1);
      repeat (CHAR_CYC - 1) @(negedge clk);
      send(WB'(12'hC3A), 1'b0, 1'b1);
      check(busy == 1'b1 && txd == 1'b0, "R8 chained start", {busy, txd}, 2'b10);
      repeat (CHAR_CYC + CPB) @(negedge clk);
      check(starts.size() >= 2 && starts[$] - starts[$-1] == CHAR_CYC,
            "R8 start spacing", starts[$] - starts[$-1], CHAR_CYC);

      // strobes while busy
      send(WB'(12'h0F0), 1'b0, 1'b1);
      repeat (3*CPB) @(negedge clk);
      send(WB'(12'hFFF), 1'b1, 1'b0);
      repeat (CHAR_CYC - 3*CPB - 3) @(negedge clk);
      send(WB'(12'h123), 1'b1, 1'b0);
      check(busy == 1'b1 && txd == 1'b1, "R7 late strobe ignored", {busy, txd}, 2'b11);
      @(negedge clk);
      check(busy == 1'b0 && txd == 1'b1, "R7 character not lengthened", {busy, txd}, 2'b01);
      repeat (2*CHAR_CYC) @(negedge clk);
      check(frames_seen == frames_sent, "R7 character count", frames_seen, frames_sent);

      // reset in the middle of a character
      mon_off = 1'b1;
      send(WB'(12'h000), 1'b0, 1'b0);
      repeat (2*CPB + 3) @(negedge clk);
      rst = 1'b1;
      #1;
      check(txd == 1'b1 && busy == 1'b0, "R9 asynchronous reset", {txd, busy}, 2'b10);
      @(negedge clk);
      rst = 1'b0;
      repeat (5) @(negedge clk);
      check(txd == 1'b1 && busy == 1'b0, "R1 idle after mid reset", {txd, busy}, 2'b10);
      mon_off = 1'b0;
      send(WB'(12'h9B6), 1'b1, 1'b1);
      repeat (CHAR_CYC + 10) @(negedge clk);
      check(expq.size() == 0, "R4 all characters seen", expq.size(), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule